// File: doc/BRIEF.md
# Entropy Clock Presence Checker

This block lets software confirm that the entropy source clock is toggling before it trusts any random value. Software requests a check with a one-cycle start pulse in the bus clock domain; in the register map this comes from a control bit that clears itself, so the bit always reads back as 0. The request crosses into the entropy clock domain as a Gray-coded sequence number. A counter there counts entropy-clock edges and saturates at a fixed count. When it gets there, it returns the sequence number it finished with to the bus domain through a synchronizer.

The bus domain shows two flags. The reveal flag rises once the count for the most recent request has completed. The clock-absent flag rises when a bus-cycle timeout expires first. Read logic downstream uses the absent flag to answer random-value reads with an error. A new start at any time clears both flags and discards any count already in progress. A completion that belongs to an older request can never set the reveal flag.

Top module: `ent_clk_probe`

## Requirements
- R1: After reset, `reveal_o` and `clk_absent_o` are both 0.
- R2: In the bus cycle after `start_i` is sampled high, `reveal_o` and `clk_absent_o` are both 0.
- R3: `reveal_o` does not rise before at least EDGES (default 4) entropy-clock rising edges have occurred after the most recent start. In the entropy domain the edge count never exceeds EDGES.
- R4: While the entropy clock runs, `reveal_o` rises within (EDGES+4) entropy-clock periods plus 4 bus cycles after the start.
- R5: Once `reveal_o` is 1, it stays 1 until the next start.
- R6: If no entropy-clock edge occurs, `clk_absent_o` is 0 for `timeout_cyc_i` bus cycles after the start edge and becomes 1 on edge number `timeout_cyc_i`+1. `reveal_o` stays 0. `timeout_cyc_i` is held stable during a check.
- R7: `clk_absent_o` falls only when `reveal_o` rises (the clock came back late) or when a new start occurs.
- R8: A start during a check restarts the edge count, so R3 counts edges from the latest start only.
- R9: `reveal_o` and `clk_absent_o` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| ent_clk_i | input | 1 | Entropy clock under test |
| start_i | input | 1 | One-cycle check request from the self-clearing test bit |
| timeout_cyc_i | input | TO_W | Bus cycles to wait before declaring the clock absent |
| reveal_o | output | 1 | Entropy clock seen toggling since the last start |
| clk_absent_o | output | 1 | Timeout expired without reveal; random reads must error |

## Verification
The assertions check on every cycle the following properties: the two flags are mutually exclusive, a start clears both flags, reveal holds until the next start, absent leaves only through reveal or a start, and the entropy-domain count saturates at EDGES. Some behaviours can only be shown by the bench's scenarios, because they depend on the relation between the two clocks. These are the minimum edge count before reveal, the latency bound for various entropy periods, the exact timeout cycle with a stopped entropy clock, late recovery, and restart in mid-check.

// File: rtl/ecp_pkg.sv
package ecp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_PASS  = 2'd2,
    ST_FAIL  = 2'd3
  } chk_st_e;
endpackage

// File: rtl/ecp_sync.sv
module ecp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/ecp_edge_cnt.sv
// Entropy-domain edge counter; echoes the finished sequence number.
module ecp_edge_cnt #(
  parameter int SEQ_W       = 3,
  parameter int EDGES       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             ent_clk_i,
  input  logic             rst_ni,
  input  logic [SEQ_W-1:0] seq_g_i,
  output logic [SEQ_W-1:0] ack_g_o
);
  localparam int CW = $clog2(EDGES + 1);

  logic [SEQ_W-1:0] seq_s, last_q, ack_q;
  logic [CW-1:0]    cnt_q;

  ecp_sync #(.W(SEQ_W), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i (ent_clk_i),
    .rst_ni(rst_ni),
    .d_i   (seq_g_i),
    .q_o   (seq_s)
  );

  always_ff @(posedge ent_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      cnt_q  <= CW'(EDGES);
      ack_q  <= '0;
    end else if (seq_s != last_q) begin
      // new request (or restart): count from zero
      last_q <= seq_s;
      cnt_q  <= '0;
    end else if (cnt_q < CW'(EDGES)) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(EDGES - 1)) ack_q <= last_q;
    end
  end

  assign ack_g_o = ack_q;
endmodule

// File: rtl/ecp_bus_ctl.sv
module ecp_bus_ctl
  import ecp_pkg::*;
#(
  parameter int SEQ_W       = 3,
  parameter int TO_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TO_W-1:0]  timeout_cyc_i,
  input  logic [SEQ_W-1:0] ack_g_i,
  output logic [SEQ_W-1:0] seq_g_o,
  output logic             reveal_o,
  output logic             clk_absent_o
);
  function automatic logic [SEQ_W-1:0] g2b(input logic [SEQ_W-1:0] g);
    logic [SEQ_W-1:0] b;
    b[SEQ_W-1] = g[SEQ_W-1];
    for (int i = SEQ_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [SEQ_W-1:0] b2g(input logic [SEQ_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  chk_st_e          st_q;
  logic [SEQ_W-1:0] seq_q, ack_s;
  logic [TO_W-1:0]  tmr_q;
  logic             done;

  ecp_sync #(.W(SEQ_W), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_g_i),
    .q_o   (ack_s)
  );

  assign done = (ack_s == seq_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      seq_q <= '0;
      tmr_q <= '0;
    end else if (start_i) begin
      seq_q <= b2g(g2b(seq_q) + 1'b1);
      tmr_q <= '0;
      st_q  <= ST_CHECK;
    end else begin
      unique case (st_q)
        ST_CHECK: begin
          if (done)                        st_q  <= ST_PASS;
          else if (tmr_q >= timeout_cyc_i) st_q  <= ST_FAIL;
          else                             tmr_q <= tmr_q + 1'b1;
        end
        ST_FAIL:  if (done) st_q <= ST_PASS;
        default:  ;
      endcase
    end
  end

  assign seq_g_o      = seq_q;
  assign reveal_o     = (st_q == ST_PASS);
  assign clk_absent_o = (st_q == ST_FAIL);
endmodule

// File: rtl/ent_clk_probe.sv
module ent_clk_probe #(
  parameter int EDGES       = 4,
  parameter int TO_W        = 16,
  parameter int SEQ_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ent_clk_i,
  input  logic            start_i,
  input  logic [TO_W-1:0] timeout_cyc_i,
  output logic            reveal_o,
  output logic            clk_absent_o
);
  logic [SEQ_W-1:0] seq_g, ack_g;

  ecp_bus_ctl #(.SEQ_W(SEQ_W), .TO_W(TO_W), .SYNC_STAGES(SYNC_STAGES)) u_bus (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .timeout_cyc_i(timeout_cyc_i),
    .ack_g_i      (ack_g),
    .seq_g_o      (seq_g),
    .reveal_o     (reveal_o),
    .clk_absent_o (clk_absent_o)
  );

  ecp_edge_cnt #(.SEQ_W(SEQ_W), .EDGES(EDGES), .SYNC_STAGES(SYNC_STAGES)) u_ent (
    .ent_clk_i(ent_clk_i),
    .rst_ni   (rst_ni),
    .seq_g_i  (seq_g),
    .ack_g_o  (ack_g)
  );
endmodule

// File: rtl/ecp_chk.sv
module ecp_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic reveal_o,
  input logic clk_absent_o
);
  // R9
  excl_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reveal_o && clk_absent_o));
  // R2
  start_clr_rev_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !reveal_o);
  // R2
  start_clr_abs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !clk_absent_o);
  // R5
  reveal_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reveal_o && !start_i) |=> reveal_o);
  // R7
  absent_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_absent_o && !start_i) |=> (clk_absent_o || reveal_o));
endmodule

module ecp_cnt_chk #(
  parameter int CW    = 3,
  parameter int EDGES = 4
) (
  input logic          ent_clk_i,
  input logic          rst_ni,
  input logic [CW-1:0] cnt_q
);
  // R3
  cnt_sat_chk: assert property (@(posedge ent_clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(EDGES));
endmodule

bind ent_clk_probe ecp_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .reveal_o    (reveal_o),
  .clk_absent_o(clk_absent_o)
);

bind ecp_edge_cnt ecp_cnt_chk #(.CW(CW), .EDGES(EDGES)) u_cnt_chk (
  .ent_clk_i(ent_clk_i),
  .rst_ni   (rst_ni),
  .cnt_q    (cnt_q)
);

// File: tb/tb_ent_clk_probe.sv
`timescale 1ns/1ps
module tb_ent_clk_probe;
  localparam int EDGES = 4;
  localparam int TO_W  = 16;

  logic clk = 1'b0, ent_clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [TO_W-1:0] tmo = 16'd100;
  logic reveal, absent;

  int  ent_half = 5;
  bit  ent_run  = 1'b1;
  int  ent_edges = 0;
  int  total = 0, bad = 0;
  bit  fin = 1'b0;

  ent_clk_probe #(.EDGES(EDGES), .TO_W(TO_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ent_clk_i(ent_clk), .start_i(start),
    .timeout_cyc_i(tmo), .reveal_o(reveal), .clk_absent_o(absent)
  );

  always #2 clk = ~clk;

  always begin
    if (ent_run) #(ent_half) ent_clk = ~ent_clk;
    else         #1;
  end

  always @(posedge ent_clk) ent_edges++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pass_deadline(input int half);
    return ((EDGES + 4) * 2 * half + 3) / 4 + 4;
  endfunction

  task automatic do_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    ent_edges = 0;
  endtask

  // waits for reveal; returns cycles waited (-1 if never) and edges at rise
  task automatic wait_reveal(input int maxc, output int cyc, output int edg);
    cyc = -1; edg = 0;
    for (int i = 0; i < maxc; i++) begin
      if (reveal) begin cyc = i; edg = ent_edges; break; end
      @(negedge clk);
    end
  endtask

  task automatic run_pass(input int half, input string tag);
    int c, e;
    ent_half = half; ent_run = 1'b1;
    do_start();
    chk(reveal == 1'b0 && absent == 1'b0, "R2 flags cleared after start", {reveal, absent}, 0);
    wait_reveal(pass_deadline(half), c, e);
    chk(c >= 0, {"R4 reveal within bound ", tag}, c, pass_deadline(half));
    chk(e >= EDGES, "R3 edges before reveal", e, EDGES);
    chk(absent == 1'b0, "R9 absent low with reveal", absent, 0);
  endtask

  task automatic run_absent(input int l, input int half);
    int c, e;
    tmo = TO_W'(l);
    ent_run = 1'b0;
    do_start();
    repeat (l) @(negedge clk);
    chk(absent == 1'b0, "R6 absent still low at timeout", absent, 0);
    @(negedge clk);
    chk(absent == 1'b1, "R6 absent high after timeout+1", absent, 1);
    chk(reveal == 1'b0, "R6 reveal low while absent", reveal, 0);
    ent_half = half; ent_run = 1'b1;
    wait_reveal(pass_deadline(half) + 2, c, e);
    chk(c >= 0 && absent == 1'b0, "R7 late clock clears absent", absent, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c, e;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk(reveal == 1'b0, "R1 reveal after reset", reveal, 0);
    chk(absent == 1'b0, "R1 absent after reset", absent, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(reveal == 1'b0 && absent == 1'b0, "R1 idle flags", {reveal, absent}, 0);

    run_pass(5, "fast");
    begin
      bit held = 1'b1;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (!reveal) held = 1'b0;
      end
      chk(held, "R5 reveal holds", held, 1);
    end
    run_pass(20, "slow");

    run_absent(30, 7);

    // R8 restart mid-check
    ent_half = 20; ent_run = 1'b1; tmo = 16'd200;
    do_start();
    while (ent_edges < 3) @(negedge clk);
    do_start();
    wait_reveal(pass_deadline(20), c, e);
    chk(c >= 0, "R8 reveal after restart", c, 0);
    chk(e >= EDGES, "R8 edges since latest start", e, EDGES);

    for (int it = 0; it < 40; it++) begin
      int half = 3 + int'($urandom_range(17));
      if ($urandom_range(3) == 0) begin
        run_absent(20 + int'($urandom_range(80)), half);
      end else begin
        tmo = TO_W'(120 + $urandom_range(200));
        run_pass(half, "rand");
      end
    end

    fin = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule